// File: doc/BRIEF.md
# Partially Self-Checking Residue ALU

This block is an 8-bit ALU whose arithmetic results are protected by a modulo-3 residue code. Each operand comes with its own 2-bit residue. For addition and subtraction, the block predicts the residue of the result from the operand residues and the carry or borrow. It then compares that prediction with a residue recomputed from the result it actually produced. The comparison is built from two-rail cells, so it yields a two-rail error pair: a complementary pair (01 or 10) means good, and an equal pair (00 or 11) means bad.

Bitwise operations cannot be covered by a low-redundancy residue code. A dual-rail check indicator, decoded from the opcode inside the block, marks each operation as "check" (10) or "skip" (01). A combining cell merges the residue error pair with this indicator into one two-rail error output:

- A checked operation passes its residue verdict through.
- A skipped operation always reports good.
- An invalid indicator always reports bad.

The result, its residue and the error pair are registered once. An 8-bit fault mask input is XOR-ed into the result before checking, so that corruption of the result can be injected.

Top module: `psc_resid_alu`

## Requirements
- R1: While rst_n is low at a rising clock edge, the outputs become alu_out=0, alu_res=0 and err_rail=01.
- R2: With op_code 000 (add), alu_out one clock later is (opd_a + opd_b) mod 256 XOR flt_mask, wrapping on carry-out.
- R3: With op_code 001 (subtract), alu_out one clock later is (opd_a - opd_b) mod 256 XOR flt_mask, wrapping on borrow.
- R4: With op_code 010 (AND), 011 (OR) and 100 (XOR), alu_out one clock later is the bitwise result XOR flt_mask, and alu_res is that alu_out value mod 3.
- R5: op_code 101, 110 and 111 yield alu_out=0 and alu_res=0, and err_rail is bad (00 or 11).
- R6: An add or subtract with flt_mask=0 and correct operand residues (res_a = opd_a mod 3, res_b = opd_b mod 3) yields a good err_rail (01 or 10).
- R7: An add or subtract whose flt_mask has exactly one bit set yields a bad err_rail, whatever the operand values.
- R8: AND, OR and XOR operations yield a good err_rail whatever the flt_mask and the residue inputs are.
- R9: An add or subtract with flt_mask=0 and a wrong operand residue yields a bad err_rail. A wrong residue is one that differs from the operand mod 3, and includes the invalid code 3.
- R10: For an add or subtract with correct operand residues, alu_res equals the fault-free result mod 3, even when flt_mask corrupts alu_out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_code | input | 3 | Operation select (000 add, 001 sub, 010 and, 011 or, 100 xor) |
| opd_a | input | 8 | First operand |
| opd_b | input | 8 | Second operand |
| res_a | input | 2 | Residue mod 3 of opd_a |
| res_b | input | 2 | Residue mod 3 of opd_b |
| flt_mask | input | 8 | Fault injection mask XOR-ed into the result |
| alu_out | output | 8 | Registered result |
| alu_res | output | 2 | Registered residue of the result |
| err_rail | output | 2 | Registered two-rail error pair (01/10 good, 00/11 bad) |

## Verification
Arithmetic is tried with operand pairs that produce a carry-out, a borrow, or neither. Because 256 mod 3 is 1, these pairs show whether the carry and borrow terms of the residue prediction are right. Every single-bit fault position is injected in both add and subtract, which shows that each bit weight changes the residue. The same faults are then applied to bitwise operations, which shows that the skip indicator masks the verdict. Wrong or invalid operand residues and unused opcodes show that the prediction path and the invalid-indicator path each force a bad pair on their own.

// File: rtl/psc_alu_pkg.sv
`timescale 1ns/1ps
// Shared constants and helpers for the residue-checked ALU.
// Assumes a 3-bit opcode and residues taken modulo 3.
package psc_alu_pkg;
    localparam logic [2:0] OP_ADD = 3'd0;
    localparam logic [2:0] OP_SUB = 3'd1;
    localparam logic [2:0] OP_AND = 3'd2;
    localparam logic [2:0] OP_OR  = 3'd3;
    localparam logic [2:0] OP_XOR = 3'd4;

    // dual-rail indicator codes and the good pair used when skipping
    localparam logic [1:0] IND_CHECK = 2'b10;
    localparam logic [1:0] IND_SKIP  = 2'b01;
    localparam logic [1:0] PAIR_GOOD = 2'b01;
    localparam logic [1:0] PAIR_BAD  = 2'b00;

    // residue modulo 3 of an unsigned value
    function automatic logic [1:0] mod3(input logic [31:0] v);
        return 2'(v % 32'd3);
    endfunction

    // true for operations the residue code covers
    function automatic logic is_arith(input logic [2:0] op);
        return (op == OP_ADD) || (op == OP_SUB);
    endfunction

    // true for bitwise operations
    function automatic logic is_logic(input logic [2:0] op);
        return (op == OP_AND) || (op == OP_OR) || (op == OP_XOR);
    endfunction
endpackage

// File: rtl/psc_alu_datapath.sv
`timescale 1ns/1ps
// Datapath: computes add/sub (wrapping) and bitwise results, exposes
// carry (add) or borrow (sub), and XORs the fault mask into valid results.
// Assumes unused opcodes must produce zero.
module psc_alu_datapath
    import psc_alu_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic [2:0]    op,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic [DW-1:0] flt,
    output logic [DW-1:0] y,
    output logic          cy
);
    logic [DW:0]   sum_w;
    logic [DW:0]   dif_w;
    logic [DW-1:0] raw;
    logic          valid_op;

    // wide add and subtract; top bit is carry or borrow
    always_comb begin
        sum_w = {1'b0, a} + {1'b0, b};
        dif_w = {1'b0, a} - {1'b0, b};
    end

    // operation select with carry/borrow routing
    always_comb begin
        raw      = '0;
        cy       = 1'b0;
        valid_op = 1'b1;
        case (op)
            OP_ADD: begin raw = sum_w[DW-1:0]; cy = sum_w[DW]; end
            OP_SUB: begin raw = dif_w[DW-1:0]; cy = dif_w[DW]; end
            OP_AND: raw = a & b;
            OP_OR:  raw = a | b;
            OP_XOR: raw = a ^ b;
            default: valid_op = 1'b0;
        endcase
    end

    // fault injection on the produced result
    always_comb y = valid_op ? (raw ^ flt) : '0;
endmodule

// File: rtl/psc_alu_resid_pred.sv
`timescale 1ns/1ps
// Residue predictor: derives the mod-3 residue of an add/sub result
// from operand residues and the carry/borrow. An operand residue of 3
// is not a codeword and yields 3, which never matches a real residue.
module psc_alu_resid_pred
    import psc_alu_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic [2:0] op,
    input  logic [1:0] ra,
    input  logic [1:0] rb,
    input  logic       cy,
    output logic [1:0] pred
);
    // 2^DW mod 3 and its additive inverse
    localparam int HIGHW = (DW % 2 == 0) ? 1 : 2;
    localparam int NEGHW = 3 - HIGHW;

    // prediction: add removes cy*2^DW, subtract adds bw*2^DW back
    always_comb begin
        if (ra == 2'd3 || rb == 2'd3) begin
            pred = 2'd3;
        end else if (op == OP_ADD) begin
            pred = mod3(32'(ra) + 32'(rb) + (cy ? 32'(NEGHW) : 32'd0));
        end else if (op == OP_SUB) begin
            pred = mod3(32'(ra) + 32'd2 * 32'(rb) + (cy ? 32'(HIGHW) : 32'd0));
        end else begin
            pred = 2'd0;
        end
    end
endmodule

// File: rtl/psc_alu_tr_cell.sv
`timescale 1ns/1ps
// Two-rail checker cell: output pair is complementary only when both
// input pairs are complementary.
module psc_alu_tr_cell (
    input  logic [1:0] x_pair,
    input  logic [1:0] y_pair,
    output logic [1:0] z_pair
);
    // cross-coupled AND-OR merge of two pairs
    always_comb begin
        z_pair[1] = (x_pair[1] & y_pair[1]) | (x_pair[0] & y_pair[0]);
        z_pair[0] = (x_pair[1] & y_pair[0]) | (x_pair[0] & y_pair[1]);
    end
endmodule

// File: rtl/psc_alu_resid_cmp.sv
`timescale 1ns/1ps
// Residue comparator: pairs each predicted bit with the inverted
// recomputed bit and folds the pairs through two-rail cells.
// Equal residues give a complementary pair, unequal an equal pair.
module psc_alu_resid_cmp #(
    parameter int RW = 2
) (
    input  logic [RW-1:0] pred,
    input  logic [RW-1:0] act,
    output logic [1:0]    pair
);
    logic [1:0] stage [RW];

    // first bit pair seeds the chain
    always_comb stage[0] = {pred[0], ~act[0]};

    for (genvar i = 1; i < RW; i++) begin : g_chain
        psc_alu_tr_cell u_cell (
            .x_pair(stage[i-1]),
            .y_pair({pred[i], ~act[i]}),
            .z_pair(stage[i])
        );
    end

    // chain end is the residue verdict
    always_comb pair = stage[RW-1];
endmodule

// File: rtl/psc_alu_mode_ind.sv
`timescale 1ns/1ps
// Check indicator: dual-rail check (10) for add/sub, skip (01) for
// bitwise operations, invalid (00) for unused opcodes.
module psc_alu_mode_ind
    import psc_alu_pkg::*;
(
    input  logic [2:0] op,
    output logic [1:0] ind
);
    // opcode class to indicator code
    always_comb begin
        if (is_arith(op))      ind = IND_CHECK;
        else if (is_logic(op)) ind = IND_SKIP;
        else                   ind = 2'b00;
    end
endmodule

// File: rtl/psc_alu_combine.sv
`timescale 1ns/1ps
// Combining cell: a checked operation passes the residue pair, a
// skipped one reports good, an invalid indicator reports bad.
module psc_alu_combine
    import psc_alu_pkg::*;
(
    input  logic [1:0] err_in,
    input  logic [1:0] ind,
    output logic [1:0] err_out
);
    // merge verdict with indicator
    always_comb begin
        case (ind)
            IND_CHECK: err_out = err_in;
            IND_SKIP:  err_out = PAIR_GOOD;
            default:   err_out = PAIR_BAD;
        endcase
    end
endmodule

// File: rtl/psc_resid_alu.sv
`timescale 1ns/1ps
// Partially self-checking residue ALU top. Registers result, result
// residue and the two-rail error pair once. Assumes the operand residues
// arrive in the same cycle as the operands.
module psc_resid_alu
    import psc_alu_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [2:0]    op_code,
    input  logic [DW-1:0] opd_a,
    input  logic [DW-1:0] opd_b,
    input  logic [1:0]    res_a,
    input  logic [1:0]    res_b,
    input  logic [DW-1:0] flt_mask,
    output logic [DW-1:0] alu_out,
    output logic [1:0]    alu_res,
    output logic [1:0]    err_rail
);
    localparam int RW = 2;

    logic [DW-1:0] y_w;
    logic          cy_w;
    logic [RW-1:0] pred_w;
    logic [RW-1:0] act_w;
    logic [1:0]    cmp_pair;
    logic [1:0]    ind_w;
    logic [1:0]    err_w;
    logic [RW-1:0] res_sel;

    psc_alu_datapath #(.DW(DW)) u_dp (
        .op(op_code), .a(opd_a), .b(opd_b), .flt(flt_mask), .y(y_w), .cy(cy_w)
    );

    psc_alu_resid_pred #(.DW(DW)) u_pred (
        .op(op_code), .ra(res_a), .rb(res_b), .cy(cy_w), .pred(pred_w)
    );

    // residue recomputed from the produced result
    always_comb act_w = mod3(32'(y_w));

    psc_alu_resid_cmp #(.RW(RW)) u_cmp (
        .pred(pred_w), .act(act_w), .pair(cmp_pair)
    );

    psc_alu_mode_ind u_ind (.op(op_code), .ind(ind_w));

    psc_alu_combine u_comb (.err_in(cmp_pair), .ind(ind_w), .err_out(err_w));

    // residue output: predicted for arithmetic, recomputed for bitwise
    always_comb begin
        if (is_arith(op_code))      res_sel = pred_w;
        else if (is_logic(op_code)) res_sel = act_w;
        else                        res_sel = '0;
    end

    // output register with synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            alu_out  <= '0;
            alu_res  <= '0;
            err_rail <= PAIR_GOOD;
        end else begin
            alu_out  <= y_w;
            alu_res  <= res_sel;
            err_rail <= err_w;
        end
    end

    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (alu_out == '0 && alu_res == 2'd0 && err_rail == PAIR_GOOD));

    // R8
    skip_good_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_logic(op_code) |=> (err_rail[1] ^ err_rail[0]));

    // R5
    badop_bad_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code > OP_XOR) |=> (!(err_rail[1] ^ err_rail[0]) && alu_out == '0));

    // R7
    fault_caught_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_arith(op_code) && $countones(flt_mask) == 1) |=> !(err_rail[1] ^ err_rail[0]));

    // R6
    clean_good_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_arith(op_code) && flt_mask == '0 && res_a == mod3(32'(opd_a))
         && res_b == mod3(32'(opd_b))) |=> (err_rail[1] ^ err_rail[0]));

    // R10
    clean_resid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_arith(op_code) && flt_mask == '0 && res_a == mod3(32'(opd_a))
         && res_b == mod3(32'(opd_b))) |=> (alu_res == mod3(32'(alu_out))));
endmodule

// File: tb/psc_resid_alu_bench.sv
`timescale 1ns/1ps
module psc_resid_alu_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] op_code = 3'd0;
    logic [7:0] opd_a = 8'd0;
    logic [7:0] opd_b = 8'd0;
    logic [1:0] res_a = 2'd0;
    logic [1:0] res_b = 2'd0;
    logic [7:0] flt_mask = 8'd0;
    logic [7:0] alu_out;
    logic [1:0] alu_res;
    logic [1:0] err_rail;

    int  total = 0;
    int  bad = 0;
    bit  done = 1'b0;

    always #2.5 clk = ~clk;

    psc_resid_alu u_psc_resid_alu (
        .clk(clk), .rst_n(rst_n), .op_code(op_code), .opd_a(opd_a), .opd_b(opd_b),
        .res_a(res_a), .res_b(res_b), .flt_mask(flt_mask),
        .alu_out(alu_out), .alu_res(alu_res), .err_rail(err_rail)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // drive one operation at a falling edge, sample at the next falling edge
    task automatic apply(input logic [2:0] op, input logic [7:0] a, input logic [7:0] b,
                         input logic [1:0] ra, input logic [1:0] rb, input logic [7:0] m);
        @(negedge clk);
        op_code = op; opd_a = a; opd_b = b; res_a = ra; res_b = rb; flt_mask = m;
        @(negedge clk);
    endtask

    function automatic int good_of(input logic [1:0] p);
        return int'(p[1] ^ p[0]);
    endfunction

    task automatic t_reset;
        op_code = 3'd0; opd_a = 8'd7; opd_b = 8'd9; res_a = 2'd1; res_b = 2'd0; flt_mask = 8'h10;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 out", int'(alu_out), 0);
        chk("R1 res", int'(alu_res), 0);
        chk("R1 err", int'(err_rail), 1);
        rst_n = 1'b1;
    endtask

    task automatic t_arith(input logic [2:0] op, input logic [7:0] a, input logic [7:0] b);
        logic [7:0] e;
        e = (op == 3'd0) ? 8'(a + b) : 8'(a - b);
        apply(op, a, b, 2'(a % 3), 2'(b % 3), 8'h00);
        chk(op == 3'd0 ? "R2 add out" : "R3 sub out", int'(alu_out), int'(e));
        chk("R6 clean good", good_of(err_rail), 1);
        chk("R10 residue", int'(alu_res), int'(e % 3));
    endtask

    task automatic t_arith_faults(input logic [2:0] op, input logic [7:0] a, input logic [7:0] b);
        logic [7:0] e;
        e = (op == 3'd0) ? 8'(a + b) : 8'(a - b);
        for (int i = 0; i < 8; i++) begin
            apply(op, a, b, 2'(a % 3), 2'(b % 3), 8'(1 << i));
            chk("R7 fault bad", good_of(err_rail), 0);
            chk(op == 3'd0 ? "R2 faulty out" : "R3 faulty out", int'(alu_out), int'(e ^ 8'(1 << i)));
            chk("R10 residue under fault", int'(alu_res), int'(e % 3));
        end
    endtask

    task automatic t_logic(input logic [7:0] a, input logic [7:0] b, input logic [7:0] m,
                           input logic [1:0] ra, input logic [1:0] rb);
        logic [7:0] e;
        for (int k = 2; k <= 4; k++) begin
            e = (k == 2) ? (a & b) : (k == 3) ? (a | b) : (a ^ b);
            e = e ^ m;
            apply(3'(k), a, b, ra, rb, m);
            chk("R4 logic out", int'(alu_out), int'(e));
            chk("R4 logic res", int'(alu_res), int'(e % 3));
            chk("R8 skip good", good_of(err_rail), 1);
        end
    endtask

    task automatic t_badop;
        for (int k = 5; k <= 7; k++) begin
            apply(3'(k), 8'h5A, 8'h33, 2'(8'h5A % 3), 2'(8'h33 % 3), 8'h00);
            chk("R5 out", int'(alu_out), 0);
            chk("R5 res", int'(alu_res), 0);
            chk("R5 err bad", good_of(err_rail), 0);
        end
    endtask

    task automatic t_bad_resid;
        apply(3'd0, 8'd10, 8'd20, 2'd0, 2'd2, 8'h00);
        chk("R9 add wrong ra", good_of(err_rail), 0);
        apply(3'd1, 8'd100, 8'd7, 2'd1, 2'd3, 8'h00);
        chk("R9 sub invalid rb", good_of(err_rail), 0);
        apply(3'd1, 8'd3, 8'd200, 2'd0, 2'd0, 8'h00);
        chk("R9 sub wrong rb", good_of(err_rail), 0);
        apply(3'd0, 8'd3, 8'd4, 2'd3, 2'd1, 8'h00);
        chk("R9 add invalid ra", good_of(err_rail), 0);
    endtask

    initial begin
        t_reset();
        t_arith(3'd0, 8'd12, 8'd30);
        t_arith(3'd0, 8'd200, 8'd100);
        t_arith(3'd0, 8'd255, 8'd1);
        t_arith(3'd1, 8'd90, 8'd31);
        t_arith(3'd1, 8'd5, 8'd10);
        t_arith(3'd1, 8'd0, 8'd255);
        t_arith(3'd1, 8'd0, 8'd0);
        t_arith_faults(3'd0, 8'd200, 8'd100);
        t_arith_faults(3'd1, 8'd5, 8'd10);
        t_logic(8'hC3, 8'h5A, 8'h00, 2'(8'hC3 % 3), 2'(8'h5A % 3));
        for (int i = 0; i < 8; i++) t_logic(8'hF0, 8'h3C, 8'(1 << i), 2'd3, 2'd1);
        t_badop();
        t_bad_resid();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog R1-side run hung actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule